// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three 16-bit down-counters on an 8-bit I/O bus. Each channel has its own data port, and one command port serves all of them. Software writes a command byte that picks a channel and its counting behaviour, then writes the start value through that channel's data port. It can freeze a channel's count, or its status and count together, and then read the frozen values back at leisure. Counting advances only in cycles where the shared counter clock enable is high.

Channel 0 drives an interrupt request line and channel 1 drives an input of an interrupt controller. Both count whenever the enable pulses, because their gates are tied high. Channel 2 is gated by a bit in a separate system control port. Its output reaches the speaker pin only while a second bit of that port is set, and the same port reports channel 2's output level when read.

Top module: `tri_interval_timer`

## Requirements
- R1: A write to address 0x43 decodes as channel = bits 7:6 (3 means read-back), access = bits 5:4, mode = bits 3:1 and BCD = bit 0. When channel is 0, 1 or 2 and access is not 00, the byte becomes that channel's configuration. This sets the null-count flag and stops counting until a new count arrives. The output goes low for mode 0 and high for any other mode.
- R2: Data ports 0x40, 0x41 and 0x42 accept the count. Access 01 writes the low byte with the high byte zero. Access 10 writes the high byte with the low byte zero. Access 11 writes the low byte first and then the high byte. A count of 0 means 65536. The new count loads on the next enabled counter clock, and that load clears the null-count flag.
- R3: In mode 0, a count N drives the output high on the Nth enabled tick after the load. The output stays high until a new count is written, and that write drives it low at once.
- R4: In mode 2 with count N, the output goes low on the (N-1)th tick after the load. It returns high one tick later, when the count reloads, and the cycle repeats every N ticks.
- R5: In mode 3, the channel counts down by 2 from N with bit 0 cleared. The output toggles every N/2 ticks, starting high.
- R6: In mode 4 with count N, the output goes low on the Nth tick after the load and returns high on the next tick. It never goes low again until the channel is reloaded.
- R7: A command byte with access 00 freezes the selected channel's count. The frozen value stays until all of its bytes have been read through the data port. Further freeze commands before then have no effect.
- R8: A read-back command has bits 7:6 = 11. In it, bit 5 = 0 freezes the count and bit 4 = 0 freezes the status, and bits 1, 2 and 3 select channels 0, 1 and 2. When both are frozen, the status byte is read first and the count bytes follow.
- R9: The status byte is {output level, null-count flag, access[1:0], mode[2:0], BCD}, MSB first.
- R10: A write to port 0x61 sets the channel 2 gate from bit 0 and the speaker enable from bit 1. A read returns {2'b00, channel 2 output, 3'b000, enable, gate}. Speaker output = channel 2 output AND enable. While the gate is 0, channel 2 neither loads nor counts.
- R11: A BCD bit of 1 is stored and reported in the status, but counting stays binary.
- R12: Read data appears on busRdData one clock after the read strobe and holds otherwise. With access 11, an unfrozen read returns the live low byte and then the live high byte, alternating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter clock enable, one tick per high cycle |
| busWr | input | 1 | I/O write strobe |
| busRd | input | 1 | I/O read strobe |
| busAddr | input | 8 | I/O address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Registered read data |
| irqOut | output | 1 | Channel 0 output, interrupt request |
| picOut | output | 1 | Channel 1 output to interrupt controller |
| spkOut | output | 1 | Channel 2 output gated by the speaker enable |

## Verification
Every channel output changes on the same clock edge that samples the tick or the bus write causing it. A command byte moves the output level right away, and a count write in mode 0 pulls it low right away. The bench therefore samples outputs at the falling edge after the driving cycle and counts load ticks separately from counting ticks. Read data is registered, so a scoreboard queues the expected byte when the read strobe is driven and compares it at the next falling edge. Frozen-value tests place ticks between the freeze and the read, so a count that is still moving would be seen.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] M_INT  = 3'd0;
  localparam logic [2:0] M_RATE = 3'd2;
  localparam logic [2:0] M_SQR  = 3'd3;
  localparam logic [2:0] M_STRB = 3'd4;

  localparam logic [1:0] RW_LATCH = 2'b00;
  localparam logic [1:0] RW_LSB   = 2'b01;
  localparam logic [1:0] RW_MSB   = 2'b10;

  typedef struct packed {
    logic modeWr;
    logic dataWr;
    logic dataRd;
    logic latchCnt;
    logic latchSts;
  } chanStb_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8,
  parameter int NUM_CH = 3,
  parameter int BASE_ADDR = 'h40,
  parameter int SYS_ADDR = 'h61
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic [BYTE_W-1:0] chanRdByte [NUM_CH],
  input  logic              gatedOut,
  output chanStb_t          stb [NUM_CH],
  output logic              gateCtl,
  output logic              outEnCtl,
  output logic [BYTE_W-1:0] busRdData
);
  localparam int SEL_W = 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(BASE_ADDR + NUM_CH);
  localparam logic [ADDR_W-1:0] SYSP_ADDR = ADDR_W'(SYS_ADDR);

  logic [SEL_W-1:0] selField;
  logic [1:0]       rwField;
  logic             ctrlHit, sysHit, readBack;
  logic [NUM_CH-1:0] dataHit;
  logic [BYTE_W-1:0] rdNext;

  assign selField = busWrData[7:6];
  assign rwField  = busWrData[5:4];
  assign ctrlHit  = busAddr == CTRL_ADDR;
  assign sysHit   = busAddr == SYSP_ADDR;
  assign readBack = busWr && ctrlHit && (selField == 2'b11);

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      dataHit[i] = busAddr == ADDR_W'(BASE_ADDR + i);
      stb[i].modeWr   = busWr && ctrlHit && selField == SEL_W'(i) && rwField != RW_LATCH;
      stb[i].latchCnt = (busWr && ctrlHit && selField == SEL_W'(i) && rwField == RW_LATCH)
                      || (readBack && !busWrData[5] && busWrData[1+i]);
      stb[i].latchSts = readBack && !busWrData[4] && busWrData[1+i];
      stb[i].dataWr   = busWr && dataHit[i];
      stb[i].dataRd   = busRd && dataHit[i];
    end
  end

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (dataHit[i]) rdNext = chanRdByte[i];
    if (sysHit) rdNext = BYTE_W'({2'b00, gatedOut, 3'b000, outEnCtl, gateCtl});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateCtl   <= 1'b0;
      outEnCtl  <= 1'b0;
      busRdData <= '0;
    end else begin
      if (busWr && sysHit) begin
        gateCtl  <= busWrData[0];
        outEnCtl <= busWrData[1];
      end
      if (busRd) busRdData <= rdNext;
    end
  end

  p_one_data_wr_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb[2].dataWr, stb[1].dataWr, stb[0].dataWr}));

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdData));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  chanStb_t          stb,
  input  logic [BYTE_W-1:0] wrByte,
  output logic [BYTE_W-1:0] rdByte,
  output logic              outLvl
);
  localparam int HI_W = CNT_W - BYTE_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [2:0]       mode;
  logic [1:0]       rw;
  logic             bcd, nullCnt, pendLoad, running, armed;
  logic             wrHigh, rdHigh, cntLatched, stsLatched;
  logic [CNT_W-1:0] cr, ce, latchVal, crNext, srcCnt;
  logic [BYTE_W-1:0] stsVal, stsNow;
  logic             wrDone, modeOk, twoByte;

  assign modeOk  = mode == M_INT || mode == M_RATE || mode == M_SQR || mode == M_STRB;
  assign twoByte = !(rw == RW_LSB || rw == RW_MSB);
  assign stsNow  = {outLvl, nullCnt, rw, mode, bcd};

  always_comb begin
    wrDone = 1'b0;
    crNext = cr;
    if (stb.dataWr) begin
      if (rw == RW_LSB) begin
        crNext = {{HI_W{1'b0}}, wrByte};
        wrDone = 1'b1;
      end else if (rw == RW_MSB) begin
        crNext = {wrByte, {(CNT_W-HI_W){1'b0}}};
        wrDone = 1'b1;
      end else if (!wrHigh) begin
        crNext[BYTE_W-1:0] = wrByte;
      end else begin
        crNext[CNT_W-1:BYTE_W] = wrByte;
        wrDone = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= '0; rw <= '0; bcd <= 1'b0; nullCnt <= 1'b0;
      pendLoad <= 1'b0; running <= 1'b0; armed <= 1'b0;
      wrHigh <= 1'b0; rdHigh <= 1'b0; cntLatched <= 1'b0; stsLatched <= 1'b0;
      cr <= '0; ce <= '0; latchVal <= '0; stsVal <= '0; outLvl <= 1'b0;
    end else if (stb.modeWr) begin
      mode       <= wrByte[3:1];
      rw         <= wrByte[5:4];
      bcd        <= wrByte[0];
      nullCnt    <= 1'b1;
      outLvl     <= wrByte[3:1] != M_INT;
      pendLoad   <= 1'b0;
      running    <= 1'b0;
      wrHigh     <= 1'b0;
      rdHigh     <= 1'b0;
      cntLatched <= 1'b0;
      stsLatched <= 1'b0;
    end else begin
      if (stb.dataWr) begin
        cr     <= crNext;
        wrHigh <= !wrDone;
        if (wrDone) begin
          pendLoad <= 1'b1;
          nullCnt  <= 1'b1;
          running  <= 1'b0;
          if (mode == M_INT) outLvl <= 1'b0;
        end
      end else if (tick) begin
        if (pendLoad) begin
          ce       <= (mode == M_SQR) ? {cr[CNT_W-1:1], 1'b0} : cr;
          pendLoad <= 1'b0;
          nullCnt  <= 1'b0;
          running  <= 1'b1;
          armed    <= 1'b1;
          if (mode != M_INT) outLvl <= 1'b1;
        end else if (running && modeOk) begin
          case (mode)
            M_INT: begin
              ce <= ce - ONE;
              if (ce == ONE) outLvl <= 1'b1;
            end
            M_RATE: begin
              if (ce == TWO) begin
                ce <= ONE;
                outLvl <= 1'b0;
              end else if (ce == ONE) begin
                ce <= cr;
                outLvl <= 1'b1;
              end else begin
                ce <= ce - ONE;
              end
            end
            M_SQR: begin
              if (ce == TWO) begin
                ce <= {cr[CNT_W-1:1], 1'b0};
                outLvl <= !outLvl;
              end else begin
                ce <= ce - TWO;
              end
            end
            default: begin
              ce <= ce - ONE;
              if (armed && ce == ONE) begin
                outLvl <= 1'b0;
              end else if (armed && !outLvl) begin
                outLvl <= 1'b1;
                armed  <= 1'b0;
              end
            end
          endcase
        end
      end
      if (stb.latchSts && !stsLatched) begin
        stsVal     <= stsNow;
        stsLatched <= 1'b1;
      end
      if (stb.latchCnt && !cntLatched) begin
        latchVal   <= ce;
        cntLatched <= 1'b1;
      end
      if (stb.dataRd) begin
        if (stsLatched) begin
          stsLatched <= 1'b0;
        end else if (twoByte && !rdHigh) begin
          rdHigh <= 1'b1;
        end else begin
          rdHigh     <= 1'b0;
          cntLatched <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    srcCnt = cntLatched ? latchVal : ce;
    if (stsLatched)                 rdByte = stsVal;
    else if (rw == RW_MSB)          rdByte = srcCnt[CNT_W-1:BYTE_W];
    else if (rw == RW_LSB)          rdByte = srcCnt[BYTE_W-1:0];
    else if (rdHigh)                rdByte = srcCnt[CNT_W-1:BYTE_W];
    else                            rdByte = srcCnt[BYTE_W-1:0];
  end

  p_mode0_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_INT && outLvl && !stb.modeWr && !stb.dataWr) |=> outLvl);

  p_strobe_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_STRB && !armed && outLvl && !stb.modeWr) |=> outLvl);

  p_latch_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cntLatched && !stb.modeWr) |=> (!cntLatched || $stable(latchVal)));

  p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !stb.modeWr) |=> $stable(ce));

  p_null_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && pendLoad && !stb.modeWr && !stb.dataWr) |=> !nullCnt);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W = 16,
  parameter int BYTE_W = 8,
  parameter int GATED_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  chanStb_t          stb [NUM_CH],
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              gateCtl,
  input  logic              outEnCtl,
  output logic [BYTE_W-1:0] chanRdByte [NUM_CH],
  output logic [NUM_CH-1:0] chanOut,
  output logic              spkOut
);
  logic [NUM_CH-1:0] chanTick;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i == GATED_CH) begin : g_gated
      assign chanTick[i] = tickEn && gateCtl;
    end else begin : g_free
      assign chanTick[i] = tickEn;
    end
    tmr_channel #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) i_chan (
      .clk(clk), .rstN(rstN), .tick(chanTick[i]), .stb(stb[i]),
      .wrByte(wrByte), .rdByte(chanRdByte[i]), .outLvl(chanOut[i])
    );
  end

  assign spkOut = chanOut[GATED_CH] && outEnCtl;

  p_spk_enable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !outEnCtl |-> !spkOut);
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  output logic              irqOut,
  output logic              picOut,
  output logic              spkOut
);
  localparam int NUM_CH = 3;
  localparam int GATED_CH = NUM_CH - 1;

  chanStb_t          stb [NUM_CH];
  logic [BYTE_W-1:0] chanRdByte [NUM_CH];
  logic [NUM_CH-1:0] chanOut;
  logic              gateCtl, outEnCtl;

  tmr_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_CH(NUM_CH)) i_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .chanRdByte(chanRdByte), .gatedOut(chanOut[GATED_CH]),
    .stb(stb), .gateCtl(gateCtl), .outEnCtl(outEnCtl), .busRdData(busRdData)
  );

  tmr_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .BYTE_W(BYTE_W), .GATED_CH(GATED_CH)) i_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .stb(stb), .wrByte(busWrData),
    .gateCtl(gateCtl), .outEnCtl(outEnCtl), .chanRdByte(chanRdByte),
    .chanOut(chanOut), .spkOut(spkOut)
  );

  assign irqOut = chanOut[0];
  assign picOut = chanOut[1];
endmodule

// File: tb/test_tri_interval_timer.sv
module test_tri_interval_timer;
  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busAddr = '0, busWrData = '0;
  logic [7:0] busRdData;
  logic irqOut, picOut, spkOut;
  int checks = 0, errors = 0;

  typedef struct { logic [7:0] val; string tag; } rdItem_t;
  rdItem_t expQ[$];
  logic rdSeen = 1'b0;

  always #2 clk = ~clk;

  tri_interval_timer i_tri_interval_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut), .picOut(picOut), .spkOut(spkOut)
  );

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic expectRead(input logic [7:0] a, input logic [7:0] e, input string tag);
    rdItem_t it;
    it.val = e; it.tag = tag;
    expQ.push_back(it);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  task automatic checkBit(input logic got, input logic e, input string tag);
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, e);
    end
  endtask

  always @(posedge clk) rdSeen <= busRd;

  always @(negedge clk) begin
    if (rdSeen) begin
      rdItem_t it;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R12: unexpected read data %h", busRdData);
      end else begin
        it = expQ.pop_front();
        if (busRdData !== it.val) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, busRdData, it.val);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkBit(irqOut, 1'b0, "reset irq");
    checkBit(picOut, 1'b0, "reset pic");
    checkBit(spkOut, 1'b0, "reset spk");
    expectRead(8'h40, 8'h00, "reset count R12");

    // mode 0 on channel 0
    busWrite(8'h43, 8'h30);
    checkBit(irqOut, 1'b0, "R1 mode0 initial low");
    busWrite(8'h43, 8'hE2);
    expectRead(8'h40, 8'h70, "R9 status after mode write");
    busWrite(8'h40, 8'h05); busWrite(8'h40, 8'h00);
    busWrite(8'h43, 8'hE2);
    expectRead(8'h40, 8'h70, "R2 null count before load");
    tick(1);
    busWrite(8'h43, 8'hE2);
    expectRead(8'h40, 8'h30, "R2 null count cleared by load");
    tick(4);
    checkBit(irqOut, 1'b0, "R3 before terminal");
    tick(1);
    checkBit(irqOut, 1'b1, "R3 at terminal");
    tick(3);
    checkBit(irqOut, 1'b1, "R3 stays high");
    busWrite(8'h43, 8'hE2);
    expectRead(8'h40, 8'hB0, "R9 output bit");
    busWrite(8'h40, 8'h03); busWrite(8'h40, 8'h00);
    checkBit(irqOut, 1'b0, "R3 rewrite drives low");

    // mode 4 on channel 0
    busWrite(8'h43, 8'h18);
    checkBit(irqOut, 1'b1, "R1 mode4 initial high");
    busWrite(8'h40, 8'h03);
    tick(1); tick(2);
    checkBit(irqOut, 1'b1, "R6 before strobe");
    tick(1);
    checkBit(irqOut, 1'b0, "R6 strobe low");
    tick(1);
    checkBit(irqOut, 1'b1, "R6 strobe ends");
    tick(10);
    checkBit(irqOut, 1'b1, "R6 single strobe");

    // mode 2 and count latch on channel 1
    busWrite(8'h43, 8'h74);
    checkBit(picOut, 1'b1, "R1 mode2 initial high");
    busWrite(8'h41, 8'h04); busWrite(8'h41, 8'h00);
    tick(1); tick(2);
    checkBit(picOut, 1'b1, "R4 before pulse");
    busWrite(8'h43, 8'h40);
    tick(1);
    checkBit(picOut, 1'b0, "R4 low pulse");
    busWrite(8'h43, 8'h40);
    tick(1);
    checkBit(picOut, 1'b1, "R4 pulse one tick");
    expectRead(8'h41, 8'h02, "R7 latched low");
    expectRead(8'h41, 8'h00, "R7 latched high, second latch ignored");
    expectRead(8'h41, 8'h04, "R12 live low");
    expectRead(8'h41, 8'h00, "R12 live high");
    tick(3);
    checkBit(picOut, 1'b0, "R4 period repeats");
    busWrite(8'h43, 8'h40);
    tick(1);
    expectRead(8'h41, 8'h01, "R7 relatch after full read");
    expectRead(8'h41, 8'h00, "R7 relatch high");

    // mode 3 on channel 2 with system port
    busWrite(8'h61, 8'h03);
    expectRead(8'h61, 8'h03, "R10 system port read");
    busWrite(8'h43, 8'hB6);
    checkBit(spkOut, 1'b1, "R1 mode3 initial high");
    busWrite(8'h42, 8'h06); busWrite(8'h42, 8'h00);
    tick(1); tick(2);
    checkBit(spkOut, 1'b1, "R5 first half");
    tick(1);
    checkBit(spkOut, 1'b0, "R5 toggle low");
    expectRead(8'h61, 8'h03, "R10 status low");
    tick(2);
    checkBit(spkOut, 1'b0, "R5 second half");
    tick(1);
    checkBit(spkOut, 1'b1, "R5 toggle high");
    expectRead(8'h61, 8'h23, "R10 status high");
    busWrite(8'h61, 8'h02);
    tick(5);
    checkBit(spkOut, 1'b1, "R10 gate low holds output");
    expectRead(8'h42, 8'h06, "R10 gate low holds count");
    busWrite(8'h61, 8'h01);
    checkBit(spkOut, 1'b0, "R10 enable off");
    expectRead(8'h61, 8'h21, "R10 enable bit read");

    // read-back of status and count, count 0 = 65536, on channel 1
    busWrite(8'h43, 8'h70);
    busWrite(8'h41, 8'h00); busWrite(8'h41, 8'h00);
    tick(2);
    busWrite(8'h43, 8'hC4);
    tick(1);
    expectRead(8'h41, 8'h30, "R8 status first");
    expectRead(8'h41, 8'hFF, "R8 latched low");
    expectRead(8'h41, 8'hFF, "R2 wrap from 65536");
    expectRead(8'h41, 8'hFE, "R8 live after latch");
    expectRead(8'h41, 8'hFF, "R8 live high");

    // BCD bit stored, binary counting
    busWrite(8'h43, 8'h31);
    busWrite(8'h43, 8'hE2);
    expectRead(8'h40, 8'h71, "R11 bcd reported");
    busWrite(8'h40, 8'h10); busWrite(8'h40, 8'h00);
    tick(2);
    expectRead(8'h40, 8'h0F, "R11 binary decrement");
    expectRead(8'h40, 8'h00, "R11 high byte");

    // MSB-only access
    busWrite(8'h43, 8'h20);
    busWrite(8'h40, 8'h01);
    tick(1);
    expectRead(8'h40, 8'h01, "R2 msb only load");
    tick(1);
    expectRead(8'h40, 8'h00, "R2 msb only count");

    @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R12: got %0d pending reads expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule